// File: doc/BRIEF.md
# Test-Port Programming Status and Error Sideband Pins

This block drives two sideband pins that let a programming station follow in-system programming without shifting status out through the serial test chain. A status pin shows whether the memories are ready or busy, and an error pin shows whether a flash erase or program step has failed. The pins stay tri-stated until the test-port instruction decoder reports an enable instruction. They are released again when it reports a disable instruction.

The error indication is sticky. It is cleared by a clear instruction, or by a chip reset that arrives after a disable instruction. When the pins are enabled, the enable instruction also chooses how both pins are driven. They can be push-pull, or open-drain so that the pins of several chained devices can be wired-OR on a board. All outputs are registered. An input seen at a clock edge shows on the pins right after that edge.

Top module: `isc_sideband_flags`

## Requirements
- R1: While `rst` is high and after it is released, with no instruction yet, all four pin outputs (`stat_o`, `stat_oe`, `err_o`, `err_oe`) are 0, and the error latch is clear.
- R2: An enable pulse (`cmd_enable`) turns both pins on. A disable pulse (`cmd_disable`) turns both off, meaning `stat_oe` = `err_oe` = 0 and `stat_o` = `err_o` = 0. When both pulses arrive in the same cycle, the disable wins.
- R3: While the pins are on, the status level is 1 (ready) exactly when neither `flash_busy` nor `ee_busy` is high, and 0 (busy) otherwise.
- R4: A `flash_fail` pulse while the pins are on sets the error latch. The error level is then 0 (active low), and it stays 0 for any number of idle cycles.
- R5: A `flash_fail` pulse while the pins are off is ignored. After a later enable, the error level is 1.
- R6: A `cmd_clear` pulse clears the error latch, and the error level returns to 1.
- R7: A `chip_rst` pulse clears the error latch only if a disable came before it and no enable came in between. A `chip_rst` pulse while the pins are on, with no prior disable, leaves the latch set.
- R8: When `flash_fail` (pins on) and `cmd_clear` arrive in the same cycle, the latch is set.
- R9: The drive style is sampled from `cmd_od` together with each enable pulse, where 0 means push-pull and 1 means open-drain. In push-pull, `pin_oe` = 1 and `pin_o` = level. In open-drain, `pin_o` = 0 and `pin_oe` = NOT level.
- R10: `ee_busy` never changes the error pin.
- R11: Every pin output changes on the first clock edge after the input that causes the change, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| cmd_enable | input | 1 | One-cycle pulse: enable instruction decoded |
| cmd_od | input | 1 | Drive style sampled with `cmd_enable` (1 = open-drain) |
| cmd_disable | input | 1 | One-cycle pulse: disable instruction decoded |
| cmd_clear | input | 1 | One-cycle pulse: clear-error instruction decoded |
| chip_rst | input | 1 | One-cycle chip reset pulse |
| flash_busy | input | 1 | Flash program or erase in progress |
| ee_busy | input | 1 | EEPROM write in progress |
| flash_fail | input | 1 | One-cycle pulse: flash erase/program step failed |
| stat_o | output | 1 | Status pin output value |
| stat_oe | output | 1 | Status pin output enable |
| err_o | output | 1 | Error pin output value |
| err_oe | output | 1 | Error pin output enable |

## Verification
The bound checker checks the following on every cycle:
- A disable pulse leaves both pins tri-stated.
- A failure seen while the pins are on always sets the latch, even when a clear arrives in the same cycle.
- A clear with no failure empties the latch.
- Failures while the pins are off never set the latch.
- The output pairs follow the push-pull or open-drain formula of the current drive style.
- The status level tracks the busy inputs of the previous cycle.

The bench's sequences show the following:
- The latch survives a chip reset given while the pins are on.
- The reset after a disable clears it, unless an enable came in between.
- Any behaviour that needs the pins to be enabled again before it can be observed.

// File: rtl/isc_flags_pkg.sv
package isc_flags_pkg;
  typedef enum logic {
    DRV_PUSH = 1'b0,
    DRV_OPEN = 1'b1
  } drive_e;

  localparam int unsigned PIN_STAT = 0;
  localparam int unsigned PIN_ERR  = 1;
  localparam int unsigned NUM_PINS = 2;
endpackage

// File: rtl/isc_mode_ctrl.sv
module isc_mode_ctrl
  import isc_flags_pkg::*;
#(
  parameter drive_e RST_DRIVE = DRV_PUSH
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   cmd_enable,
  input  logic   cmd_od,
  input  logic   cmd_disable,
  input  logic   chip_rst,
  output logic   on_q,
  output logic   on_d,
  output drive_e drv_q,
  output drive_e drv_d,
  output logic   wipe
);
  logic arm_q, arm_d;

  always_comb begin
    on_d  = on_q;
    drv_d = drv_q;
    arm_d = arm_q;
    if (chip_rst) arm_d = 1'b0;
    if (cmd_disable) begin
      on_d  = 1'b0;
      arm_d = 1'b1;
    end else if (cmd_enable) begin
      on_d  = 1'b1;
      drv_d = drive_e'(cmd_od);
      arm_d = 1'b0;
    end
  end

  // a chip reset counts only when a disable is pending
  assign wipe = chip_rst & arm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q  <= 1'b0;
      drv_q <= RST_DRIVE;
      arm_q <= 1'b0;
    end else begin
      on_q  <= on_d;
      drv_q <= drv_d;
      arm_q <= arm_d;
    end
  end
endmodule

// File: rtl/isc_err_latch.sv
module isc_err_latch (
  input  logic clk,
  input  logic rst,
  input  logic on_q,
  input  logic flash_fail,
  input  logic cmd_clear,
  input  logic wipe,
  output logic err_q,
  output logic err_d
);
  always_comb begin
    err_d = err_q;
    if (cmd_clear || wipe) err_d = 1'b0;
    if (flash_fail && on_q) err_d = 1'b1;  // failure has priority
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= err_d;
  end
endmodule

// File: rtl/isc_pin_drive.sv
module isc_pin_drive
  import isc_flags_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   on_d,
  input  drive_e drv_d,
  input  logic   level_d,
  output logic   pin_o,
  output logic   pin_oe
);
  logic o_d, oe_d;

  always_comb begin
    o_d  = 1'b0;
    oe_d = 1'b0;
    if (on_d) begin
      if (drv_d == DRV_OPEN) begin
        o_d  = 1'b0;
        oe_d = ~level_d;
      end else begin
        o_d  = level_d;
        oe_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o  <= 1'b0;
      pin_oe <= 1'b0;
    end else begin
      pin_o  <= o_d;
      pin_oe <= oe_d;
    end
  end
endmodule

// File: rtl/isc_sideband_flags.sv
module isc_sideband_flags
  import isc_flags_pkg::*;
#(
  parameter drive_e RST_DRIVE = DRV_PUSH
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_enable,
  input  logic cmd_od,
  input  logic cmd_disable,
  input  logic cmd_clear,
  input  logic chip_rst,
  input  logic flash_busy,
  input  logic ee_busy,
  input  logic flash_fail,
  output logic stat_o,
  output logic stat_oe,
  output logic err_o,
  output logic err_oe
);
  logic   on_q, on_d, wipe, err_q, err_d;
  drive_e drv_q, drv_d;
  logic [NUM_PINS-1:0] level_d, pin_o, pin_oe;

  isc_mode_ctrl #(.RST_DRIVE(RST_DRIVE)) u_mode (
    .clk(clk), .rst(rst), .cmd_enable(cmd_enable), .cmd_od(cmd_od),
    .cmd_disable(cmd_disable), .chip_rst(chip_rst),
    .on_q(on_q), .on_d(on_d), .drv_q(drv_q), .drv_d(drv_d), .wipe(wipe)
  );

  isc_err_latch u_err (
    .clk(clk), .rst(rst), .on_q(on_q), .flash_fail(flash_fail),
    .cmd_clear(cmd_clear), .wipe(wipe), .err_q(err_q), .err_d(err_d)
  );

  // pin levels: ready high, error active low
  assign level_d[PIN_STAT] = ~(flash_busy | ee_busy);
  assign level_d[PIN_ERR]  = ~err_d;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    isc_pin_drive u_drv (
      .clk(clk), .rst(rst), .on_d(on_d), .drv_d(drv_d),
      .level_d(level_d[p]), .pin_o(pin_o[p]), .pin_oe(pin_oe[p])
    );
  end

  assign stat_o  = pin_o[PIN_STAT];
  assign stat_oe = pin_oe[PIN_STAT];
  assign err_o   = pin_o[PIN_ERR];
  assign err_oe  = pin_oe[PIN_ERR];
endmodule

// File: rtl/isc_sideband_flags_chk.sv
module isc_sideband_flags_chk (
  input logic clk,
  input logic rst,
  input logic cmd_disable,
  input logic cmd_clear,
  input logic flash_busy,
  input logic ee_busy,
  input logic flash_fail,
  input logic stat_o,
  input logic stat_oe,
  input logic err_o,
  input logic err_oe,
  input logic on_q,
  input logic od_q,
  input logic err_q
);
  // R2
  a_r2_disable_tristate: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_disable) |-> (!stat_oe && !err_oe && !stat_o && !err_o));
  // R4 and R8
  a_r4_fail_sets: assert property (@(posedge clk) disable iff (rst)
    $past(flash_fail && on_q) |-> err_q);
  // R6
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_clear && !flash_fail) |-> !err_q);
  // R5
  a_r5_off_ignores: assert property (@(posedge clk) disable iff (rst)
    $past(!on_q && !err_q) |-> !err_q);
  // R9
  a_r9_push_pull: assert property (@(posedge clk) disable iff (rst)
    (on_q && !od_q) |-> (stat_oe && err_oe && (err_o == !err_q)));
  a_r9_open_drain: assert property (@(posedge clk) disable iff (rst)
    (on_q && od_q) |-> (!stat_o && !err_o && (err_oe == err_q)));
  // R3
  a_r3_status_level: assert property (@(posedge clk) disable iff (rst)
    (on_q && !od_q) |-> (stat_o == !$past(flash_busy || ee_busy)));
endmodule

bind isc_sideband_flags isc_sideband_flags_chk u_chk (
  .clk(clk), .rst(rst), .cmd_disable(cmd_disable), .cmd_clear(cmd_clear),
  .flash_busy(flash_busy), .ee_busy(ee_busy), .flash_fail(flash_fail),
  .stat_o(stat_o), .stat_oe(stat_oe), .err_o(err_o), .err_oe(err_oe),
  .on_q(on_q), .od_q(drv_q), .err_q(err_q)
);

// File: tb/tb_isc_sideband_flags.sv
module tb_isc_sideband_flags;
  logic clk = 1'b0;
  logic rst;
  logic cmd_enable, cmd_od, cmd_disable, cmd_clear, chip_rst;
  logic flash_busy, ee_busy, flash_fail;
  logic stat_o, stat_oe, err_o, err_oe;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mode_od = 1'b0;

  always #2.5 clk = ~clk;

  isc_sideband_flags dut (
    .clk(clk), .rst(rst), .cmd_enable(cmd_enable), .cmd_od(cmd_od),
    .cmd_disable(cmd_disable), .cmd_clear(cmd_clear), .chip_rst(chip_rst),
    .flash_busy(flash_busy), .ee_busy(ee_busy), .flash_fail(flash_fail),
    .stat_o(stat_o), .stat_oe(stat_oe), .err_o(err_o), .err_oe(err_oe)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic lvl(logic o, logic oe);
    return mode_od ? ~oe : o;
  endfunction

  // inputs driven at negedge; one tick passes one posedge and returns at negedge
  task automatic tick();
    @(negedge clk);
    cmd_enable = 0; cmd_disable = 0; cmd_clear = 0; chip_rst = 0; flash_fail = 0;
  endtask

  task automatic enable(bit od);
    cmd_enable = 1; cmd_od = od; mode_od = od; tick();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; cmd_enable = 0; cmd_od = 0; cmd_disable = 0; cmd_clear = 0;
    chip_rst = 0; flash_busy = 0; ee_busy = 0; flash_fail = 0;
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", {stat_o, stat_oe, err_o, err_oe}, 0);
    rst = 0; tick();
    check("R1 outputs after reset", {stat_o, stat_oe, err_o, err_oe}, 0);

    // R5: failure while off is ignored
    flash_fail = 1; tick();
    enable(0);
    check("R2 enable drives pins", {stat_oe, err_oe}, 3);
    check("R5 error level after off-time failure", lvl(err_o, err_oe), 1);

    // R3 R9 R10 sweep over drive style and busy inputs
    for (int m = 0; m < 2; m++) begin
      enable(m[0]);
      for (int b = 0; b < 4; b++) begin
        flash_busy = b[0]; ee_busy = b[1]; tick();
        check("R3 status level", lvl(stat_o, stat_oe), (b == 0) ? 1 : 0);
        check("R10 error level with busy", lvl(err_o, err_oe), 1);
        if (m == 1) check("R9 open-drain stat pair", {stat_o, stat_oe}, (b == 0) ? 0 : 1);
        else        check("R9 push-pull stat pair", {stat_o, stat_oe}, (b == 0) ? 3 : 1);
      end
      flash_busy = 0; ee_busy = 0; tick();
    end

    // R11 latency: still in open-drain mode
    flash_busy = 1; #1;
    check("R11 no change before edge", lvl(stat_o, stat_oe), 1);
    tick();
    check("R11 change after edge", lvl(stat_o, stat_oe), 0);
    flash_busy = 0; tick();

    // R4 sticky
    flash_fail = 1; tick();
    check("R4 error set", lvl(err_o, err_oe), 0);
    check("R9 open-drain err pair", {err_o, err_oe}, 1);
    repeat (5) tick();
    check("R4 error sticky", lvl(err_o, err_oe), 0);
    // R6
    cmd_clear = 1; tick();
    check("R6 clear", lvl(err_o, err_oe), 1);
    // R8
    flash_fail = 1; cmd_clear = 1; tick();
    check("R8 fail beats clear", lvl(err_o, err_oe), 0);
    // R7: reset while on does not clear
    chip_rst = 1; tick();
    check("R7 reset while on keeps error", lvl(err_o, err_oe), 0);
    // disable then reset clears
    cmd_disable = 1; tick();
    check("R2 disable tri-states", {stat_o, stat_oe, err_o, err_oe}, 0);
    chip_rst = 1; tick();
    enable(0);
    check("R7 reset after disable clears", lvl(err_o, err_oe), 1);
    // disable, enable, then reset: pending disable cancelled
    flash_fail = 1; tick();
    cmd_disable = 1; tick();
    enable(0);
    chip_rst = 1; tick();
    check("R7 enable cancels pending reset clear", lvl(err_o, err_oe), 0);
    cmd_clear = 1; tick();
    check("R6 clear again", lvl(err_o, err_oe), 1);
    // R2 same-cycle disable and enable
    cmd_disable = 1; cmd_enable = 1; tick();
    check("R2 disable wins", {stat_oe, err_oe}, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule